// File: doc/BRIEF.md
# Multi-Stream Timestamp Alignment Buffer

This block brings several packet streams back into step after they have crossed paths of unequal delay. Every input link runs on the same phase-locked reference clock but may carry a different phase offset. Each link writes into its own buffer. The first word of every packet carries a timestamp. The block examines the packet waiting at the front of each buffer. It releases a set of packets only when all of those front packets carry the same timestamp. When the front timestamps differ, the packet that is furthest behind in time is thrown away as a whole. The other links keep their packets and wait for the late links to catch up.

A matched set leaves on one wide output bus, one word per cycle. Each link has its own lane on that bus. A flag marks the words of an aligned set, and separate markers give the first and last word. A sticky flag records that some link buffer received a word while it was full. A packet has a fixed length: two header words followed by a number of payload words set by a parameter.

Top module: `ts_align_buffer`

## Requirements
- R1: During and straight after reset, `out_aligned`, `out_sop`, `out_eop` and `overflow` are all low.
- R2: Each link stores its words in arrival order. A packet is `PAYLOAD_WORDS+2` words long. Word 0 holds the timestamp in its low 32 bits, word 1 is a second header word, and the payload words follow.
- R3: No output word appears until every link holds at least one complete packet in its buffer.
- R4: When all front timestamps are equal, the packets are released together, one word per cycle, with `out_aligned` high for `PAYLOAD_WORDS+2` consecutive cycles. Lane i of `out_data` (bits `i*DATA_W +: DATA_W`) carries link i's word.
- R5: `out_sop` is high with the timestamp word of a released set and `out_eop` with its last payload word. Neither is high while `out_aligned` is low.
- R6: When the front timestamps differ, only the packet with the oldest timestamp is discarded, as a whole. The links are scanned in ascending index, and a link replaces the current choice only if its timestamp is strictly older, so a tie discards the lowest-indexed link first.
- R7: Timestamps are ordered modulo 2^32. a is older than b when (a-b), taken as a 32-bit signed value, is negative, so ordering continues correctly across the wrap from all ones to zero.
- R8: `overflow` rises in the cycle after a word arrives at a link whose buffer already holds `FIFO_DEPTH` words. It then stays high until reset. After it rises, the buffer contents are undefined until reset.
- R9: A link that receives a word in the same cycle that its front word is being read or discarded takes both actions, with no word lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N_LINKS | Per-link word strobe |
| in_data | input | N_LINKS*DATA_W | Per-link word, lane i at bits i*DATA_W |
| out_aligned | output | 1 | High for each word of a matched set |
| out_sop | output | 1 | First (timestamp) word of a set |
| out_eop | output | 1 | Last word of a set |
| out_data | output | N_LINKS*DATA_W | Lanes of the released words |
| overflow | output | 1 | Sticky: a word reached a full link buffer |

## Verification
The two functions that collide are a link receiving a new word and the same link losing its front word, either to the lockstep release or to a discard. Both affect the buffer's occupancy in the same cycle. The bench feeds all links at random rates with random gaps in their timestamp sequences, and some links carry extra early packets, so arrivals keep landing during releases and discards. Every released word is compared against packets predicted by a packet-level model of the matching and discard rules. A lost or repeated word would shift a lane and show up as a data mismatch.

// File: rtl/align_pkg.sv
package align_pkg;

  // Width of the timestamp field held in the low bits of header word 0.
  localparam int unsigned TS_W = 32;

  typedef enum logic [1:0] {
    ST_CMP  = 2'd0,
    ST_DROP = 2'd1,
    ST_SEND = 2'd2
  } align_st_e;

  // Modular age test: a is older than b when a-b is negative.
  function automatic logic ts_older(input logic [TS_W-1:0] a,
                                    input logic [TS_W-1:0] b);
    logic [TS_W-1:0] diff;
    diff = a - b;
    return diff[TS_W-1];
  endfunction

  // A link is ready when it holds at least one whole packet.
  function automatic logic has_packet(input int unsigned level,
                                      input int unsigned pkt_len);
    return level >= pkt_len;
  endfunction

endpackage

// File: rtl/align_link_fifo.sv
module align_link_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [W-1:0]             push_data,
  input  logic                     pop,
  output logic [W-1:0]             head,
  output logic [$clog2(DEPTH):0]   level,
  output logic                     full_hit
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned LW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          full;
  logic          accept;

  assign full     = (level == LW'(DEPTH));
  assign accept   = push && !full;
  assign full_hit = push && full;
  assign head     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (accept) begin
      mem[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (accept) begin
        wr_ptr <= wr_ptr + AW'(1);
      end
      if (pop) begin
        rd_ptr <= rd_ptr + AW'(1);
      end
      level <= level + LW'(accept) - LW'(pop);
    end
  end

endmodule

// File: rtl/align_ts_compare.sv
module align_ts_compare
  import align_pkg::*;
#(
  parameter int unsigned N = 4,
  parameter int unsigned W = 32
) (
  input  logic [N*W-1:0]         heads,
  input  logic [N-1:0]           ready,
  output logic                   all_ready,
  output logic                   all_match,
  output logic [$clog2(N)-1:0]   oldest
);
  localparam int unsigned IW = $clog2(N);

  logic [TS_W-1:0] lane_ts [N];

  for (genvar g = 0; g < N; g++) begin : g_ts
    assign lane_ts[g] = heads[g*W +: TS_W];
  end

  always_comb begin
    logic [TS_W-1:0] best_ts;
    all_ready = &ready;
    all_match = 1'b1;
    oldest    = '0;
    best_ts   = lane_ts[0];
    for (int i = 1; i < N; i++) begin
      if (lane_ts[i] != lane_ts[0]) begin
        all_match = 1'b0;
      end
      if (ts_older(lane_ts[i], best_ts)) begin
        best_ts = lane_ts[i];
        oldest  = IW'(i);
      end
    end
  end

endmodule

// File: rtl/align_seq_ctrl.sv
module align_seq_ctrl
  import align_pkg::*;
#(
  parameter int unsigned N       = 4,
  parameter int unsigned PKT_LEN = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   all_ready,
  input  logic                   all_match,
  input  logic [$clog2(N)-1:0]   oldest,
  output logic [N-1:0]           pop,
  output logic                   sending,
  output logic                   first_word,
  output logic                   last_word
);
  localparam int unsigned IW = $clog2(N);
  localparam int unsigned CW = $clog2(PKT_LEN);

  align_st_e     st;
  logic [CW-1:0] wcnt;
  logic [IW-1:0] victim;
  logic          at_end;

  assign at_end = (wcnt == CW'(PKT_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_CMP;
      wcnt   <= '0;
      victim <= '0;
    end else begin
      unique case (st)
        ST_CMP: begin
          wcnt <= '0;
          if (all_ready) begin
            if (all_match) begin
              st <= ST_SEND;
            end else begin
              st     <= ST_DROP;
              victim <= oldest;
            end
          end
        end
        ST_DROP, ST_SEND: begin
          if (at_end) begin
            st   <= ST_CMP;
            wcnt <= '0;
          end else begin
            wcnt <= wcnt + CW'(1);
          end
        end
        default: st <= ST_CMP;
      endcase
    end
  end

  always_comb begin
    pop = '0;
    if (st == ST_SEND) begin
      pop = '1;
    end else if (st == ST_DROP) begin
      pop[victim] = 1'b1;
    end
  end

  assign sending    = (st == ST_SEND);
  assign first_word = sending && (wcnt == '0);
  assign last_word  = sending && at_end;

endmodule

// File: rtl/ts_align_buffer.sv
module ts_align_buffer
  import align_pkg::*;
#(
  parameter int unsigned N_LINKS       = 4,
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned FIFO_DEPTH    = 64,
  parameter int unsigned PAYLOAD_WORDS = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_LINKS-1:0]          in_valid,
  input  logic [N_LINKS*DATA_W-1:0]   in_data,
  output logic                        out_aligned,
  output logic                        out_sop,
  output logic                        out_eop,
  output logic [N_LINKS*DATA_W-1:0]   out_data,
  output logic                        overflow
);
  localparam int unsigned PKT_LEN = PAYLOAD_WORDS + 2;
  localparam int unsigned LVW     = $clog2(FIFO_DEPTH) + 1;
  localparam int unsigned IW      = $clog2(N_LINKS);

  logic [N_LINKS*DATA_W-1:0] heads;
  logic [N_LINKS-1:0]        pop_vec;
  logic [N_LINKS-1:0]        link_ready;
  logic [N_LINKS-1:0]        link_empty;
  logic [N_LINKS-1:0]        link_full_hit;
  logic [LVW-1:0]            level [N_LINKS];

  logic                      all_ready;
  logic                      all_match;
  logic [IW-1:0]             oldest;
  logic                      sending;
  logic                      first_word;
  logic                      last_word;

  for (genvar g = 0; g < N_LINKS; g++) begin : g_link
    align_link_fifo #(
      .W     (DATA_W),
      .DEPTH (FIFO_DEPTH)
    ) i_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (in_valid[g]),
      .push_data (in_data[g*DATA_W +: DATA_W]),
      .pop       (pop_vec[g]),
      .head      (heads[g*DATA_W +: DATA_W]),
      .level     (level[g]),
      .full_hit  (link_full_hit[g])
    );
    assign link_ready[g] = has_packet(int'(level[g]), PKT_LEN);
    assign link_empty[g] = (level[g] == '0);
  end

  align_ts_compare #(
    .N (N_LINKS),
    .W (DATA_W)
  ) i_cmp (
    .heads     (heads),
    .ready     (link_ready),
    .all_ready (all_ready),
    .all_match (all_match),
    .oldest    (oldest)
  );

  align_seq_ctrl #(
    .N       (N_LINKS),
    .PKT_LEN (PKT_LEN)
  ) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .all_ready  (all_ready),
    .all_match  (all_match),
    .oldest     (oldest),
    .pop        (pop_vec),
    .sending    (sending),
    .first_word (first_word),
    .last_word  (last_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_aligned <= 1'b0;
      out_sop     <= 1'b0;
      out_eop     <= 1'b0;
      out_data    <= '0;
      overflow    <= 1'b0;
    end else begin
      out_aligned <= sending;
      out_sop     <= first_word;
      out_eop     <= last_word;
      if (sending) begin
        out_data <= heads;
      end
      if (|link_full_hit) begin
        overflow <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ts_align_buffer_chk.sv
module ts_align_buffer_chk #(
  parameter int unsigned N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         out_aligned,
  input logic         out_sop,
  input logic         out_eop,
  input logic         overflow,
  input logic [N-1:0] pop_vec,
  input logic [N-1:0] link_empty
);

  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_vec & link_empty) == '0);                                   // R3
  AST_LOCKSTEP_OR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop_vec) || (&pop_vec));                                // R4
  AST_SOP_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> out_aligned);                                        // R5
  AST_EOP_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |-> out_aligned);                                        // R5
  AST_NEW_SET_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |=> (!out_aligned || out_sop));                          // R5
  AST_SET_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_aligned && !out_sop) |-> $past(out_aligned));               // R4
  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);                                          // R8

endmodule

bind ts_align_buffer ts_align_buffer_chk #(.N(N_LINKS)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .out_aligned (out_aligned),
  .out_sop     (out_sop),
  .out_eop     (out_eop),
  .overflow    (overflow),
  .pop_vec     (pop_vec),
  .link_empty  (link_empty)
);

// File: tb/test_ts_align_buffer.sv
module test_ts_align_buffer;
  localparam int N    = 4;
  localparam int W    = 32;
  localparam int PL   = 6;
  localparam int PKT  = PL + 2;
  localparam int NPK  = 30;
  localparam int MAXP = NPK + 3;
  localparam logic [31:0] BASE = 32'hFFFF_FFF0;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   in_valid = '0;
  logic [N*W-1:0] in_data = '0;
  logic           out_aligned;
  logic           out_sop;
  logic           out_eop;
  logic [N*W-1:0] out_data;
  logic           overflow;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] lts [N][MAXP];
  int          lcnt [N];
  logic [31:0] exp_ts [MAXP];
  int          n_exp = 0;
  int          grp = 0;
  int          wi = 0;

  always #5 clk = ~clk;

  ts_align_buffer #(
    .N_LINKS(N), .DATA_W(W), .FIFO_DEPTH(64), .PAYLOAD_WORDS(PL)
  ) i_ts_align_buffer (.*);

  function automatic bit older(input logic [31:0] a, input logic [31:0] b);
    return $signed(a - b) < 0;
  endfunction

  function automatic logic [31:0] word_of(input int link, input logic [31:0] ts, input int k);
    if (k == 0) return ts;
    if (k == 1) return {8'hA5, 8'(link), ts[15:0]};
    return (ts * 32'h9E37_79B1) ^ (32'(link) << 24) ^ 32'(k);
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Output monitor: compares every released word with the packet model.
  always @(negedge clk) begin
    if (rst_n && out_aligned) begin
      if (grp >= n_exp) begin
        check(0, "R3 unexpected aligned output", out_data, '0);
      end else begin
        logic [N*W-1:0] e;
        for (int l = 0; l < N; l++) e[l*W +: W] = word_of(l, exp_ts[grp], wi);
        check(out_data == e, "R2 R4 R6 R7 R9 lane data", out_data, e);
        check(out_sop == (wi == 0) && out_eop == (wi == PKT - 1),
              "R5 sop/eop position", {out_sop, out_eop},
              {(wi == 0), (wi == PKT - 1)});
      end
      wi++;
      if (wi == PKT) begin
        wi = 0;
        grp++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int pk [N];
    int wk [N];
    seed = $urandom(32'd20240611);

    // Per-link timestamp lists: optional early extras, random gaps, wrap at k=16.
    for (int l = 0; l < N; l++) begin
      bit extra;
      lcnt[l] = 0;
      extra = ($urandom % 2) != 0;
      for (int k = -3; k < NPK; k++) begin
        bit take;
        if (k < 0) take = extra && (($urandom % 2) != 0);
        else       take = ($urandom % 16) != 0;
        if (take) begin
          lts[l][lcnt[l]] = BASE + 32'(k);
          lcnt[l]++;
        end
      end
    end

    // Packet-level model of matching and discard (R6, R7).
    begin
      int p [N];
      for (int l = 0; l < N; l++) p[l] = 0;
      while (1) begin
        bit stop;
        bit eq;
        int b;
        stop = 0;
        for (int l = 0; l < N; l++) if (p[l] >= lcnt[l]) stop = 1;
        if (stop) break;
        eq = 1;
        for (int l = 1; l < N; l++) if (lts[l][p[l]] != lts[0][p[0]]) eq = 0;
        if (eq) begin
          exp_ts[n_exp] = lts[0][p[0]];
          n_exp++;
          for (int l = 0; l < N; l++) p[l]++;
        end else begin
          b = 0;
          for (int l = 1; l < N; l++) if (older(lts[l][p[l]], lts[b][p[b]])) b = l;
          p[b]++;
        end
      end
    end

    repeat (3) @(negedge clk);
    check({out_aligned, out_sop, out_eop, overflow} == 4'b0, "R1 reset outputs",
          {out_aligned, out_sop, out_eop, overflow}, 4'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check({out_aligned, out_sop, out_eop, overflow} == 4'b0, "R1 after reset release",
          {out_aligned, out_sop, out_eop, overflow}, 4'b0);

    // Random phase: independent per-link rates, mild lead throttle.
    for (int l = 0; l < N; l++) begin
      pk[l] = 0;
      wk[l] = 0;
    end
    while (1) begin
      bit busy;
      int mn;
      busy = 0;
      for (int l = 0; l < N; l++) if (pk[l] < lcnt[l]) busy = 1;
      if (!busy) break;
      @(negedge clk);
      mn = 1000;
      for (int l = 0; l < N; l++) if (pk[l] < lcnt[l] && pk[l] < mn) mn = pk[l];
      for (int l = 0; l < N; l++) begin
        bit go;
        in_valid[l] = 1'b0;
        if (pk[l] < lcnt[l]) begin
          go = ($urandom % 3) == 0;
          if (wk[l] == 0 && pk[l] - mn >= 3) go = 0;
          if (go) begin
            in_valid[l] = 1'b1;
            in_data[l*W +: W] = word_of(l, lts[l][pk[l]], wk[l]);
            wk[l]++;
            if (wk[l] == PKT) begin
              wk[l] = 0;
              pk[l]++;
            end
          end
        end
      end
    end
    @(negedge clk);
    in_valid = '0;
    repeat (120) @(negedge clk);
    check(grp == n_exp, "R3 R4 released set count", 128'(grp), 128'(n_exp));
    check(wi == 0, "R4 no partial set", 128'(wi), 0);
    check(overflow == 1'b0, "R8 no overflow under throttled load", 128'(overflow), 0);

    // Directed: fill link 0 alone past its depth.
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int n = 0; n < 70; n++) begin
      @(negedge clk);
      if (n == 64) check(overflow == 1'b0, "R8 exactly full is not overflow", 128'(overflow), 0);
      in_valid[0] = 1'b1;
      in_data[0 +: W] = 32'h1234_0000 + 32'(n);
    end
    @(negedge clk);
    in_valid = '0;
    check(overflow == 1'b1, "R8 overflow latched", 128'(overflow), 1);
    repeat (10) @(negedge clk);
    check(overflow == 1'b1, "R8 overflow sticky", 128'(overflow), 1);
    check(out_aligned == 1'b0, "R3 one link alone gives no output", 128'(out_aligned), 0);
    rst_n = 1'b0;
    @(negedge clk);
    check(overflow == 1'b0, "R1 reset clears overflow", 128'(overflow), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule